// File: doc/BRIEF.md
# Boundary Scan Pad Interception Cells

This block is a chain of boundary-scan cells placed between the core-side signals and the pad-side signals of a group of IO pins. Each pin is given a kind when the block is elaborated: input only, output only, output with tristate enable, or bidirectional. Every wire the pin actually has (input, output, output enable) gets one interception cell. Each cell contributes two bits to the scan chain, one that observes the wire's source and one that drives the wire's destination.

With the mode select low, every wire passes straight from core to pad or from pad to core. With it high, all destinations are driven from update-held values, and the sources are only sampled by capture. The pad side and the core side therefore sit on separate chain bits. A test sequence can drive a pad while it reads what the peripheral tried to drive, or feed the peripheral while it reads the pad's level, and in this way tell a broken pad from a broken peripheral. The test access state machine and instruction decoding are outside the block. Its capture, shift and update strobes, the mode select and the scan data arrive as inputs in the test clock domain.

Top module: `bscan_pad_chain`

## Requirements
- R1: With scan_mode low and rst_n high, core_i follows pad_i on input and bidirectional pins, pad_o follows core_o on every pin that has an output, and pad_oe follows core_oe on tristate and bidirectional pins, all combinationally.
- R2: PIN_KINDS holds two bits per pin, pin p in bits [2p+1:2p]: 0 input, 1 output, 2 tristate output, 3 bidirectional. Missing wires are tied off: core_i is 0 on pins with no input wire, pad_oe is 1 on output-only pins, and pad_o and pad_oe are 0 on input-only pins, in every mode.
- R3: Chain bit 0 is the bit next to tdo. The pins follow each other in index order. Within a pin the bits run as pad-input observe, core-input drive, core-output observe, pad-output drive, core-enable observe, pad-enable drive, and bits for absent wires are left out. For the default kinds (0,1,2,3) this gives 14 bits, with drive bits 1, 3, 5, 7, 9, 11 and 13. Each tck edge with shift high moves every bit one place toward tdo and loads tdi into the last bit.
- R4: A tck edge with capture high loads every observe bit with its current source (pad_i, core_o or core_oe) and leaves the drive bits unchanged.
- R5: A tck edge with update high, and with capture and shift low, copies the drive bits into hold registers. With scan_mode high, core_i, pad_o and pad_oe on real wires come from those hold registers and stay unchanged across shift and capture cycles.
- R6: With scan_mode high, changes on core_o, core_oe or pad_i do not reach pad_o, pad_oe or core_i. They can still be captured, on bits separate from the ones that drive the opposite side.
- R7: While rst_n is low, the outputs follow the functional path of R1 whatever scan_mode is. A tck edge with rst_n low clears all shift stages and hold registers to 0.
- R8: When strobes coincide, capture takes priority over shift. Update has no effect in a cycle where capture or shift is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low test reset; also forces functional mode |
| scan_mode | input | 1 | 1 selects interception, 0 selects straight-through |
| capture | input | 1 | Load observe bits on this tck edge |
| shift | input | 1 | Shift the chain by one bit on this tck edge |
| update | input | 1 | Copy drive bits into hold registers on this tck edge |
| tdi | input | 1 | Scan data in, enters the last chain bit |
| tdo | output | 1 | Scan data out, chain bit 0 |
| core_o | input | NPINS | Output values from the peripheral |
| core_oe | input | NPINS | Output enables from the peripheral |
| core_i | output | NPINS | Input values delivered to the peripheral |
| pad_i | input | NPINS | Levels seen at the pads |
| pad_o | output | NPINS | Output values sent to the pads |
| pad_oe | output | NPINS | Output enables sent to the pads |

## Verification
The hardest case to reach is proving that one chain position drives exactly one pad-side or core-side wire. A chain position is only visible from the ports after a full serial load and an update, and a misplaced bit looks correct as long as a shifted vector simply comes back out unchanged. The stimulus therefore walks a single 1 through each drive position in turn, loads it serially, applies update and checks that exactly one output changes. Capture is exercised with drive bits preloaded with a known pattern, so that a capture which overwrote drive positions would show up in the read-back.

// File: rtl/bscan_pkg.sv
// Shared definitions for the boundary-scan pad cells.
// Assumes at most MAX_PINS pins per chain; pin kinds packed two bits per pin.
package bscan_pkg;

    typedef enum logic [1:0] {
        PK_IN    = 2'd0,
        PK_OUT   = 2'd1,
        PK_TRI   = 2'd2,
        PK_BIDIR = 2'd3
    } pin_kind_e;

    localparam int MAX_PINS  = 32;
    localparam int KIND_BITS = 2 * MAX_PINS;

    // Extract the kind of pin p from the packed kind vector.
    function automatic pin_kind_e kind_at(input logic [KIND_BITS-1:0] kinds, input int p);
        return pin_kind_e'(kinds[2*p +: 2]);
    endfunction

    function automatic bit has_in(input pin_kind_e k);
        return (k == PK_IN) || (k == PK_BIDIR);
    endfunction

    function automatic bit has_out(input pin_kind_e k);
        return k != PK_IN;
    endfunction

    function automatic bit has_oe(input pin_kind_e k);
        return (k == PK_TRI) || (k == PK_BIDIR);
    endfunction

    // Number of intercepted wires of a pin kind (one cell each).
    function automatic int wire_count(input pin_kind_e k);
        return int'(has_in(k)) + int'(has_out(k)) + int'(has_oe(k));
    endfunction

endpackage

// File: rtl/bscan_cell.sv
// One interception cell for a single wire: an observe stage sampling the
// wire's source, a drive stage, and a hold register feeding the destination
// in scan mode. Chain order inside the cell: observe stage is nearer tdo.
// Assumes all strobes are synchronous to tck.
module bscan_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic scan_en,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic sin,
    input  logic src,
    output logic sout,
    output logic dst
);

    logic obs_q;
    logic drv_q;
    logic hold_q;

    // Shift stages: capture has priority over shift.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            obs_q <= 1'b0;
            drv_q <= 1'b0;
        end else if (capture) begin
            obs_q <= src;
        end else if (shift) begin
            obs_q <= drv_q;
            drv_q <= sin;
        end
    end

    // Hold register: loaded only by a lone update strobe.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (update && !capture && !shift) begin
            hold_q <= drv_q;
        end
    end

    assign sout = obs_q;
    assign dst  = scan_en ? hold_q : src;

endmodule

// File: rtl/bscan_pin.sv
// Boundary-scan cells for one pin. KIND picks which of the three wires
// (input, output, output enable) exist; one cell per wire, chained in
// that order from the tdo side. Absent wires are tied to fixed values.
module bscan_pin #(
    parameter bscan_pkg::pin_kind_e KIND = bscan_pkg::PK_BIDIR
) (
    input  logic tck,
    input  logic rst_n,
    input  logic scan_en,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic sin,
    output logic sout,
    input  logic core_o,
    input  logic core_oe,
    output logic core_i,
    input  logic pad_i,
    output logic pad_o,
    output logic pad_oe
);

    localparam bit HAS_I  = bscan_pkg::has_in(KIND);
    localparam bit HAS_O  = bscan_pkg::has_out(KIND);
    localparam bit HAS_OE = bscan_pkg::has_oe(KIND);
    localparam int NC     = bscan_pkg::wire_count(KIND);
    localparam int IX_O   = HAS_I ? 1 : 0;
    localparam int IX_OE  = IX_O + 1;

    logic [NC:0] chn;
    logic        unused_pin;

    assign chn[NC]    = sin;
    assign sout       = chn[0];
    assign unused_pin = ^{pad_i, core_o, core_oe};

    // Input wire: pad level observed, core input driven.
    if (HAS_I) begin : g_in
        bscan_cell u_cell (
            .tck(tck), .rst_n(rst_n), .scan_en(scan_en),
            .capture(capture), .shift(shift), .update(update),
            .sin(chn[1]), .src(pad_i), .sout(chn[0]), .dst(core_i)
        );
    end else begin : g_no_in
        assign core_i = 1'b0;
    end

    // Output wire: core value observed, pad output driven.
    if (HAS_O) begin : g_out
        bscan_cell u_cell (
            .tck(tck), .rst_n(rst_n), .scan_en(scan_en),
            .capture(capture), .shift(shift), .update(update),
            .sin(chn[IX_O+1]), .src(core_o), .sout(chn[IX_O]), .dst(pad_o)
        );
    end else begin : g_no_out
        assign pad_o = 1'b0;
    end

    // Enable wire: core enable observed, pad enable driven.
    if (HAS_OE) begin : g_oe
        bscan_cell u_cell (
            .tck(tck), .rst_n(rst_n), .scan_en(scan_en),
            .capture(capture), .shift(shift), .update(update),
            .sin(chn[IX_OE+1]), .src(core_oe), .sout(chn[IX_OE]), .dst(pad_oe)
        );
    end else begin : g_no_oe
        assign pad_oe = HAS_O;
    end

endmodule

// File: rtl/bscan_pad_chain.sv
// Chain of per-pin boundary-scan cells between core and pads.
// Pin 0 sits next to tdo, the last pin next to tdi. Reset forces the
// straight-through path. Assumes NPINS <= bscan_pkg::MAX_PINS.
module bscan_pad_chain #(
    parameter int                 NPINS     = 4,
    parameter logic [2*NPINS-1:0] PIN_KINDS = 8'hE4
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             scan_mode,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    output logic             tdo,
    input  logic [NPINS-1:0] core_o,
    input  logic [NPINS-1:0] core_oe,
    output logic [NPINS-1:0] core_i,
    input  logic [NPINS-1:0] pad_i,
    output logic [NPINS-1:0] pad_o,
    output logic [NPINS-1:0] pad_oe
);

    localparam int KB = bscan_pkg::KIND_BITS;
    localparam logic [KB-1:0] KINDS_EXT = KB'(PIN_KINDS);

    logic [NPINS:0] link;
    logic           scan_en;

    // Interception only while out of reset and scan mode selected.
    assign scan_en     = scan_mode & rst_n;
    assign link[NPINS] = tdi;
    assign tdo         = link[0];

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam bscan_pkg::pin_kind_e K = bscan_pkg::kind_at(KINDS_EXT, p);
        bscan_pin #(.KIND(K)) u_pin (
            .tck(tck), .rst_n(rst_n), .scan_en(scan_en),
            .capture(capture), .shift(shift), .update(update),
            .sin(link[p+1]), .sout(link[p]),
            .core_o(core_o[p]), .core_oe(core_oe[p]), .core_i(core_i[p]),
            .pad_i(pad_i[p]), .pad_o(pad_o[p]), .pad_oe(pad_oe[p])
        );
    end

endmodule

// File: rtl/bscan_chk.sv
// Property checker for bscan_pad_chain, bound to every instance.
// Observes ports only; assumes the same parameters as the checked instance.
module bscan_chk #(
    parameter int                 NPINS     = 4,
    parameter logic [2*NPINS-1:0] PIN_KINDS = 8'hE4
) (
    input logic             tck,
    input logic             rst_n,
    input logic             scan_mode,
    input logic             capture,
    input logic             shift,
    input logic             update,
    input logic             tdi,
    input logic             tdo,
    input logic [NPINS-1:0] core_o,
    input logic [NPINS-1:0] core_oe,
    input logic [NPINS-1:0] core_i,
    input logic [NPINS-1:0] pad_i,
    input logic [NPINS-1:0] pad_o,
    input logic [NPINS-1:0] pad_oe
);

    localparam int KB = bscan_pkg::KIND_BITS;
    localparam logic [KB-1:0] KX = KB'(PIN_KINDS);
    localparam bscan_pkg::pin_kind_e K0 = bscan_pkg::kind_at(KX, 0);

    logic unused_chk;
    assign unused_chk = ^{tdi, shift};

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam bscan_pkg::pin_kind_e K = bscan_pkg::kind_at(KX, p);

        if (bscan_pkg::has_in(K)) begin : g_i
            AST_FUNC_IN: assert property (@(posedge tck) disable iff (!rst_n)
                !scan_mode |-> core_i[p] == pad_i[p]); // R1
        end else begin : g_ni
            AST_CORE_IN_TIED: assert property (@(posedge tck) disable iff (!rst_n)
                core_i[p] == 1'b0); // R2
        end

        if (bscan_pkg::has_out(K)) begin : g_o
            AST_FUNC_OUT: assert property (@(posedge tck) disable iff (!rst_n)
                !scan_mode |-> pad_o[p] == core_o[p]); // R1
            // Reset forces the straight path on outputs.
            always @(negedge tck) begin
                if (!rst_n) AST_RST_BYPASS: assert (pad_o[p] == core_o[p]); // R7
            end
        end

        if (bscan_pkg::has_oe(K)) begin : g_oe
            AST_FUNC_OE: assert property (@(posedge tck) disable iff (!rst_n)
                !scan_mode |-> pad_oe[p] == core_oe[p]); // R1
        end else begin : g_noe
            AST_OE_TIED: assert property (@(posedge tck) disable iff (!rst_n)
                pad_oe[p] == bscan_pkg::has_out(K)); // R2
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(rst_n) && scan_mode && $past(scan_mode) && !$past(update))
        |-> ($stable(pad_o) && $stable(pad_oe) && $stable(core_i))); // R5

    if (bscan_pkg::has_in(K0)) begin : g_cap0
        AST_TDO_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
            ($past(capture) && $past(rst_n)) |-> tdo == $past(pad_i[0])); // R4
    end else begin : g_cap0
        AST_TDO_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
            ($past(capture) && $past(rst_n)) |-> tdo == $past(core_o[0])); // R4
    end

endmodule

bind bscan_pad_chain bscan_chk #(.NPINS(NPINS), .PIN_KINDS(PIN_KINDS)) u_chk (.*);

// File: tb/bscan_pad_chain_bench.sv
// Self-checking bench for bscan_pad_chain with default kinds
// (pin0 input, pin1 output, pin2 tristate, pin3 bidirectional, 14 bits).
module bscan_pad_chain_bench;

    localparam int PERIOD = 10;
    localparam int NP     = 4;
    localparam int LEN    = 14;

    logic tck = 1'b0;
    always #(PERIOD/2) tck = ~tck;

    logic          rst_n, scan_mode, capture, shift, update, tdi, tdo;
    logic [NP-1:0] core_o, core_oe, core_i, pad_i, pad_o, pad_oe;

    bscan_pad_chain #(.NPINS(NP), .PIN_KINDS(8'hE4)) u_bscan_pad_chain (
        .tck(tck), .rst_n(rst_n), .scan_mode(scan_mode),
        .capture(capture), .shift(shift), .update(update),
        .tdi(tdi), .tdo(tdo),
        .core_o(core_o), .core_oe(core_oe), .core_i(core_i),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Functional vectors: pad_i, core_o, core_oe -> core_i, pad_o, pad_oe (R1, R2).
    typedef struct packed {
        logic [3:0] pi, co, coe, e_ci, e_po, e_poe;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2},
        '{4'hF, 4'hF, 4'hF, 4'h9, 4'hE, 4'hE},
        '{4'h5, 4'hA, 4'h3, 4'h1, 4'hA, 4'h2},
        '{4'hA, 4'h5, 4'hC, 4'h8, 4'h4, 4'hE},
        '{4'h9, 4'h6, 4'h4, 4'h9, 4'h6, 4'h6},
        '{4'h6, 4'h9, 4'h8, 4'h0, 4'h8, 4'hA}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected scan-mode outputs from hold bits (drive positions of R3).
    function automatic logic [3:0] x_ci(input logic [LEN-1:0] h);
        return {h[9], 2'b00, h[1]};
    endfunction
    function automatic logic [3:0] x_po(input logic [LEN-1:0] h);
        return {h[11], h[5], h[3], 1'b0};
    endfunction
    function automatic logic [3:0] x_poe(input logic [LEN-1:0] h);
        return {h[13], h[7], 2'b10};
    endfunction

    // Expected chain after capture: observe positions replaced (R3, R4).
    function automatic logic [LEN-1:0] x_cap(input logic [LEN-1:0] old,
            input logic [3:0] pi, input logic [3:0] co, input logic [3:0] coe);
        logic [LEN-1:0] r = old;
        r[0]  = pi[0];
        r[2]  = co[1];
        r[4]  = co[2];
        r[6]  = coe[2];
        r[8]  = pi[3];
        r[10] = co[3];
        r[12] = coe[3];
        return r;
    endfunction

    task automatic chk_outs(input string req, input logic [LEN-1:0] h);
        chk(req, "core_i", 32'(core_i), 32'(x_ci(h)));
        chk(req, "pad_o",  32'(pad_o),  32'(x_po(h)));
        chk(req, "pad_oe", 32'(pad_oe), 32'(x_poe(h)));
    endtask

    // Shift LEN bits: vin[0] goes in first; vout[k] is tdo before shift k.
    task automatic shift_vec(input logic [LEN-1:0] vin, output logic [LEN-1:0] vout);
        for (int k = 0; k < LEN; k++) begin
            @(negedge tck);
            vout[k] = tdo;
            tdi     = vin[k];
            shift   = 1'b1;
        end
        @(negedge tck);
        shift = 1'b0;
        tdi   = 1'b0;
    endtask

    task automatic pulse(input logic c, input logic s, input logic u);
        @(negedge tck);
        capture = c; shift = s; update = u;
        @(negedge tck);
        capture = 1'b0; shift = 1'b0; update = 1'b0;
    endtask

    task automatic set_in(input logic [3:0] pi, input logic [3:0] co, input logic [3:0] coe);
        pad_i = pi; core_o = co; core_oe = coe;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] got;
        rst_n = 1'b0; scan_mode = 1'b1; capture = 1'b0; shift = 1'b0;
        update = 1'b0; tdi = 1'b0;
        set_in(4'h3, 4'hA, 4'h5);
        repeat (3) @(negedge tck);
        // R7: reset forces straight-through even with scan_mode high.
        chk("R7", "rst core_i", 32'(core_i), 32'h1);
        chk("R7", "rst pad_o",  32'(pad_o),  32'hA);
        chk("R7", "rst pad_oe", 32'(pad_oe), 32'h6);
        rst_n = 1'b1;
        @(negedge tck);
        chk_outs("R7", '0); // hold cleared by reset

        // R1/R2: table walk in functional mode.
        scan_mode = 1'b0;
        foreach (VECS[i]) begin
            @(negedge tck);
            set_in(VECS[i].pi, VECS[i].co, VECS[i].coe);
            #1;
            chk("R1", "core_i", 32'(core_i), 32'(VECS[i].e_ci));
            chk("R1", "pad_o",  32'(pad_o),  32'(VECS[i].e_po));
            chk("R2", "pad_oe", 32'(pad_oe), 32'(VECS[i].e_poe));
        end

        // R7: stages cleared; R3: serial round trip.
        shift_vec(14'h2AAA, got);
        chk("R7", "stages after reset", 32'(got), 32'h0);
        shift_vec(14'h1234, got);
        chk("R3", "round trip", 32'(got), 32'h2AAA);

        // R3/R5: walk a single 1 through every drive position.
        scan_mode = 1'b1;
        for (int k = 1; k < LEN; k += 2) begin
            shift_vec(LEN'(1) << k, got);
            pulse(1'b0, 1'b0, 1'b1);
            chk_outs("R3", LEN'(1) << k);
        end

        // R5/R6: held outputs ignore core/pad changes and further shifting.
        shift_vec(14'h2AAA, got);
        pulse(1'b0, 1'b0, 1'b1);
        chk_outs("R5", 14'h2AAA);
        set_in(4'h0, 4'h0, 4'h0);
        @(negedge tck);
        chk_outs("R6", 14'h2AAA);
        set_in(4'hF, 4'hF, 4'hF);
        @(negedge tck);
        chk_outs("R6", 14'h2AAA);
        shift_vec(14'h0000, got);
        chk_outs("R5", 14'h2AAA);

        // R4: capture fills observe bits, keeps drive bits.
        shift_vec(14'h2AAA, got);
        set_in(4'h9, 4'hE, 4'hC);
        pulse(1'b1, 1'b0, 1'b0);
        chk_outs("R6", 14'h2AAA);
        shift_vec(14'h0000, got);
        chk("R4", "capture all ones", 32'(got), 32'(x_cap(14'h2AAA, 4'h9, 4'hE, 4'hC)));
        set_in(4'h6, 4'h1, 4'h3);
        pulse(1'b1, 1'b0, 1'b0);
        shift_vec(14'h0000, got);
        chk("R4", "capture zeros", 32'(got), 32'(x_cap(14'h0000, 4'h6, 4'h1, 4'h3)));

        // R8: capture beats shift.
        shift_vec(14'h2AAA, got);
        set_in(4'hF, 4'hF, 4'hF);
        pulse(1'b1, 1'b1, 1'b0);
        shift_vec(14'h0000, got);
        chk("R8", "capture over shift", 32'(got), 32'(x_cap(14'h2AAA, 4'hF, 4'hF, 4'hF)));
        // R8: update ignored alongside shift (hold still 0x2AAA).
        pulse(1'b0, 1'b1, 1'b1);
        chk_outs("R8", 14'h2AAA);
        pulse(1'b0, 1'b0, 1'b1);
        chk_outs("R5", 14'h0000);

        // R7: reset in scan mode reverts to straight path and clears hold.
        shift_vec(14'h2AAA, got);
        pulse(1'b0, 1'b0, 1'b1);
        chk_outs("R5", 14'h2AAA);
        set_in(4'h0, 4'h0, 4'h0);
        @(negedge tck);
        rst_n = 1'b0;
        #1;
        chk("R7", "reset core_i", 32'(core_i), 32'h0);
        chk("R7", "reset pad_o",  32'(pad_o),  32'h0);
        chk("R7", "reset pad_oe", 32'(pad_oe), 32'h2);
        @(negedge tck);
        rst_n = 1'b1;
        set_in(4'hF, 4'hF, 4'hF);
        @(negedge tck);
        chk_outs("R7", 14'h0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule